// File: doc/BRIEF.md
# Operand-Snooping Reservation Station Bank

This block holds the instructions that are waiting for one type of functional unit. Examples are a pair of multiply stations or a pair of store stations. Each station keeps an opcode and two operand slots. A slot holds either a finished value or the tag of the station whose result it still needs. Instructions arrive through an issue port, one per cycle and in program order. A station that is waiting snoops the common result bus and copies a broadcast value into every slot whose tag matches. When both operands of a station are present, the station offers its instruction to the functional unit through a valid/ready handshake. If more than one station is ready, the lowest-numbered one goes first.

Every station has a fixed tag, `BASE_TAG + index`. The unit later broadcasts the result under this tag and reports completion under the same tag. A station stays busy from issue until the unit reports completion, and then becomes free.

On a misprediction flush, stations that have not yet dispatched are discarded at once. A station whose instruction is already inside the unit moves to a drain state. It cannot be reused until the unit reports completion for it.

Each station runs a state machine with five states:
- FREE
- WAIT (at least one operand missing)
- READY (both operands present, not yet dispatched)
- EXEC (in the unit)
- DRAIN (in the unit, flushed)

Its transitions are:
- FREE→WAIT on issue with an operand missing.
- FREE→READY on issue with both operands available.
- WAIT→READY when the last missing operand is captured from the bus.
- WAIT→FREE and READY→FREE on flush.
- READY→EXEC on dispatch.
- EXEC→FREE on completion.
- EXEC→DRAIN on flush without completion.
- DRAIN→FREE on completion.

Top module: `rs_bank`

## Requirements
- R1: After reset every station is free, `issue_ready` is 1, `issue_tag` equals `BASE_TAG`, and `disp_valid` is 0.
- R2: `issue_tag` always shows the tag `BASE_TAG + i` of the lowest-numbered free station `i`. An issue with `issue_valid` and `issue_ready` both high writes the opcode and operands into that station at the clock edge.
- R3: When no station is free, `issue_ready` is 0 and an instruction presented on the issue port is dropped. It never reaches dispatch.
- R4: A slot issued with its ready bit set keeps the given value. A slot issued with its ready bit clear takes `cdb_data` on the first cycle in which `cdb_valid` is high and `cdb_tag` equals its stored tag. Broadcasts with any other tag leave the slot unchanged.
- R5: A broadcast in the same cycle as the issue, whose tag matches a not-ready source tag, fills that slot. No later broadcast is then needed.
- R6: In the cycle after a station holds both operands, `disp_valid` is 1 and the port shows its opcode, both operand values and its tag. The station is handed over at a clock edge where `disp_valid` and `disp_ready` are both high.
- R7: When several stations are ready, the lowest-numbered one is offered on the dispatch port.
- R8: A dispatched station stays busy until `done_valid` is high with `done_tag` equal to its tag. It is free from the next cycle on.
- R9: During a cycle with `flush` high, `issue_ready` and `disp_valid` are 0. After the edge, every station that had not dispatched is free and never dispatches.
- R10: A station that is executing when `flush` arrives stays busy, and cannot be allocated, until its completion arrives. It is free after that completion edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction offered for issue |
| issue_op | input | OP_W | Opcode |
| issue_a_rdy | input | 1 | Operand A carries a value (1) or a tag (0) |
| issue_a_val | input | DATA_W | Operand A value |
| issue_a_tag | input | TAG_W | Operand A producer tag |
| issue_b_rdy | input | 1 | Operand B carries a value (1) or a tag (0) |
| issue_b_val | input | DATA_W | Operand B value |
| issue_b_tag | input | TAG_W | Operand B producer tag |
| issue_ready | output | 1 | A station is free and no flush is active |
| issue_tag | output | TAG_W | Tag of the station an issue would take |
| cdb_valid | input | 1 | Result broadcast present |
| cdb_tag | input | TAG_W | Tag of the broadcast producer |
| cdb_data | input | DATA_W | Broadcast result value |
| disp_valid | output | 1 | A ready station is offered to the unit |
| disp_ready | input | 1 | Functional unit accepts an instruction |
| disp_op | output | OP_W | Dispatched opcode |
| disp_a | output | DATA_W | Dispatched operand A |
| disp_b | output | DATA_W | Dispatched operand B |
| disp_tag | output | TAG_W | Tag of the dispatched station |
| flush | input | 1 | Discard all speculative instructions |
| done_valid | input | 1 | Functional unit completed an operation |
| done_tag | input | TAG_W | Tag of the completed operation |

## Verification
Four stations are first loaded while the unit is held off. They get a mix of all-value operands, one-tag operands and two-tag operands. Broadcasts then arrive with matching and non-matching tags. The scoreboard's dispatch order and operand values show whether capture was selective and whether the lowest-ready choice was made.

A broadcast in the issue cycle tells apart the same-cycle capture path from a missed capture, which would leave the station stuck waiting. A single instruction traced cycle by cycle through dispatch and completion pins down the exact edge on which a station frees.

A flush with one station executing, one waiting and one ready tells apart dropping from draining. The allocation tag afterwards shows whether the executing station was reused too early.

// File: rtl/rs_pkg.sv
package rs_pkg;

    // Life cycle of one station.
    typedef enum logic [2:0] {
        RS_FREE  = 3'd0,
        RS_WAIT  = 3'd1,
        RS_READY = 3'd2,
        RS_EXEC  = 3'd3,
        RS_DRAIN = 3'd4
    } rs_state_e;

endpackage

// File: rtl/rs_pick.sv
// Lowest-index priority picker, used for allocation and for dispatch.
module rs_pick #(
    parameter int unsigned N     = 4,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req_i,
    output logic [N-1:0]     gnt_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
        any_o = |req_i;
        gnt_o = any_o ? ({{(N-1){1'b0}}, 1'b1} << idx_o) : '0;
    end

endmodule

// File: rtl/rs_slot.sv
// One operand slot: value or producer tag, filled by a bus snoop.
module rs_slot #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              load_rdy_i,
    input  logic [DATA_W-1:0] load_val_i,
    input  logic [TAG_W-1:0]  load_tag_i,
    input  logic              cdb_valid_i,
    input  logic [TAG_W-1:0]  cdb_tag_i,
    input  logic [DATA_W-1:0] cdb_data_i,
    output logic              load_ok_o,
    output logic              fill_o,
    output logic [DATA_W-1:0] val_o
);

    logic              rdy_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] val_q;
    logic              load_hit;
    logic              snoop_hit;

    assign load_hit  = cdb_valid_i && (cdb_tag_i == load_tag_i);
    assign snoop_hit = cdb_valid_i && !rdy_q && (cdb_tag_i == tag_q);
    assign load_ok_o = load_rdy_i || load_hit;
    assign fill_o    = rdy_q || snoop_hit;
    assign val_o     = val_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q <= 1'b0;
            tag_q <= '0;
            val_q <= '0;
        end else if (load_i) begin
            rdy_q <= load_rdy_i || load_hit;
            tag_q <= load_tag_i;
            val_q <= load_rdy_i ? load_val_i : cdb_data_i;
        end else if (snoop_hit) begin
            rdy_q <= 1'b1;
            val_q <= cdb_data_i;
        end
    end

endmodule

// File: rtl/rs_entry.sv
// One reservation station: opcode, two snooping slots, state machine.
module rs_entry
    import rs_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned TAG_W  = 4,
    parameter int unsigned OP_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic              a_rdy_i,
    input  logic [DATA_W-1:0] a_val_i,
    input  logic [TAG_W-1:0]  a_tag_i,
    input  logic              b_rdy_i,
    input  logic [DATA_W-1:0] b_val_i,
    input  logic [TAG_W-1:0]  b_tag_i,
    input  logic              cdb_valid_i,
    input  logic [TAG_W-1:0]  cdb_tag_i,
    input  logic [DATA_W-1:0] cdb_data_i,
    input  logic              fire_i,
    input  logic              flush_i,
    input  logic              done_i,
    output rs_state_e         st_o,
    output logic              free_o,
    output logic              ready_o,
    output logic [OP_W-1:0]   op_o,
    output logic [DATA_W-1:0] a_o,
    output logic [DATA_W-1:0] b_o
);

    rs_state_e       st_q, st_d;
    logic [OP_W-1:0] op_q;
    logic            a_ok, b_ok, a_fill, b_fill;

    rs_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W)) slot_a_i (
        .clk(clk), .rst_n(rst_n), .load_i(alloc_i),
        .load_rdy_i(a_rdy_i), .load_val_i(a_val_i), .load_tag_i(a_tag_i),
        .cdb_valid_i(cdb_valid_i), .cdb_tag_i(cdb_tag_i), .cdb_data_i(cdb_data_i),
        .load_ok_o(a_ok), .fill_o(a_fill), .val_o(a_o)
    );

    rs_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W)) slot_b_i (
        .clk(clk), .rst_n(rst_n), .load_i(alloc_i),
        .load_rdy_i(b_rdy_i), .load_val_i(b_val_i), .load_tag_i(b_tag_i),
        .cdb_valid_i(cdb_valid_i), .cdb_tag_i(cdb_tag_i), .cdb_data_i(cdb_data_i),
        .load_ok_o(b_ok), .fill_o(b_fill), .val_o(b_o)
    );

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RS_FREE:  if (alloc_i) st_d = (a_ok && b_ok) ? RS_READY : RS_WAIT;
            RS_WAIT:  if (flush_i) st_d = RS_FREE;
                      else if (a_fill && b_fill) st_d = RS_READY;
            RS_READY: if (flush_i) st_d = RS_FREE;
                      else if (fire_i) st_d = RS_EXEC;
            RS_EXEC:  if (done_i) st_d = RS_FREE;
                      else if (flush_i) st_d = RS_DRAIN;
            RS_DRAIN: if (done_i) st_d = RS_FREE;
            default:  st_d = RS_FREE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= RS_FREE;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= '0;
        end else if (alloc_i) begin
            op_q <= op_i;
        end
    end

    // Outputs.
    always_comb begin
        st_o    = st_q;
        free_o  = (st_q == RS_FREE);
        ready_o = (st_q == RS_READY);
        op_o    = op_q;
    end

endmodule

// File: rtl/rs_bank.sv
module rs_bank
    import rs_pkg::*;
#(
    parameter int unsigned NUM_RS   = 4,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned TAG_W    = 4,
    parameter int unsigned OP_W     = 3,
    parameter int unsigned BASE_TAG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [OP_W-1:0]   issue_op,
    input  logic              issue_a_rdy,
    input  logic [DATA_W-1:0] issue_a_val,
    input  logic [TAG_W-1:0]  issue_a_tag,
    input  logic              issue_b_rdy,
    input  logic [DATA_W-1:0] issue_b_val,
    input  logic [TAG_W-1:0]  issue_b_tag,
    output logic              issue_ready,
    output logic [TAG_W-1:0]  issue_tag,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    output logic              disp_valid,
    input  logic              disp_ready,
    output logic [OP_W-1:0]   disp_op,
    output logic [DATA_W-1:0] disp_a,
    output logic [DATA_W-1:0] disp_b,
    output logic [TAG_W-1:0]  disp_tag,
    input  logic              flush,
    input  logic              done_valid,
    input  logic [TAG_W-1:0]  done_tag
);

    localparam int unsigned IDX_W = (NUM_RS > 1) ? $clog2(NUM_RS) : 1;

    rs_state_e          st_arr [NUM_RS];
    logic [OP_W-1:0]    op_arr [NUM_RS];
    logic [DATA_W-1:0]  a_arr  [NUM_RS];
    logic [DATA_W-1:0]  b_arr  [NUM_RS];

    logic [NUM_RS-1:0]  v_free, v_ready, v_wait, v_exec, v_drain;
    logic [NUM_RS-1:0]  alloc_oh, disp_oh, alloc_vec, fire_vec, done_hit;
    logic [IDX_W-1:0]   alloc_idx, disp_idx;
    logic               any_free, any_ready, issue_go;

    rs_pick #(.N(NUM_RS)) alloc_pick_i (
        .req_i(v_free), .gnt_o(alloc_oh), .idx_o(alloc_idx), .any_o(any_free)
    );

    rs_pick #(.N(NUM_RS)) disp_pick_i (
        .req_i(v_ready), .gnt_o(disp_oh), .idx_o(disp_idx), .any_o(any_ready)
    );

    assign issue_ready = any_free && !flush;
    assign issue_go    = issue_valid && issue_ready;
    assign issue_tag   = TAG_W'(BASE_TAG) + TAG_W'(alloc_idx);
    assign disp_valid  = any_ready && !flush;
    assign disp_tag    = TAG_W'(BASE_TAG) + TAG_W'(disp_idx);

    for (genvar g = 0; g < NUM_RS; g++) begin : g_st
        logic st_free, st_ready;

        assign alloc_vec[g] = issue_go && alloc_oh[g];
        assign fire_vec[g]  = disp_valid && disp_ready && disp_oh[g];
        assign done_hit[g]  = done_valid && (done_tag == TAG_W'(BASE_TAG + g));

        rs_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W)) entry_i (
            .clk(clk), .rst_n(rst_n), .alloc_i(alloc_vec[g]), .op_i(issue_op),
            .a_rdy_i(issue_a_rdy), .a_val_i(issue_a_val), .a_tag_i(issue_a_tag),
            .b_rdy_i(issue_b_rdy), .b_val_i(issue_b_val), .b_tag_i(issue_b_tag),
            .cdb_valid_i(cdb_valid), .cdb_tag_i(cdb_tag), .cdb_data_i(cdb_data),
            .fire_i(fire_vec[g]), .flush_i(flush), .done_i(done_hit[g]),
            .st_o(st_arr[g]), .free_o(st_free), .ready_o(st_ready),
            .op_o(op_arr[g]), .a_o(a_arr[g]), .b_o(b_arr[g])
        );

        assign v_free[g]  = st_free;
        assign v_ready[g] = st_ready;
        assign v_wait[g]  = (st_arr[g] == RS_WAIT);
        assign v_exec[g]  = (st_arr[g] == RS_EXEC);
        assign v_drain[g] = (st_arr[g] == RS_DRAIN);
    end

    // One-hot OR multiplexer onto the dispatch port.
    always_comb begin
        disp_op = '0;
        disp_a  = '0;
        disp_b  = '0;
        for (int i = 0; i < NUM_RS; i++) begin
            if (disp_oh[i]) begin
                disp_op = disp_op | op_arr[i];
                disp_a  = disp_a  | a_arr[i];
                disp_b  = disp_b  | b_arr[i];
            end
        end
    end

endmodule

// File: rtl/rs_bank_chk.sv
module rs_bank_chk #(
    parameter int unsigned NUM_RS   = 4,
    parameter int unsigned TAG_W    = 4,
    parameter int unsigned BASE_TAG = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              issue_ready,
    input logic [TAG_W-1:0]  issue_tag,
    input logic              disp_valid,
    input logic              disp_ready,
    input logic [TAG_W-1:0]  disp_tag,
    input logic [NUM_RS-1:0] v_free,
    input logic [NUM_RS-1:0] v_wait,
    input logic [NUM_RS-1:0] v_ready,
    input logic [NUM_RS-1:0] v_exec,
    input logic [NUM_RS-1:0] v_drain,
    input logic [NUM_RS-1:0] done_hit
);

    p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ((v_wait | v_ready) == '0));

    p_fire_to_exec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ready) |=> ((v_exec | v_drain) != '0));

    for (genvar g = 0; g < NUM_RS; g++) begin : g_chk
        p_alloc_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (issue_ready && issue_tag == TAG_W'(BASE_TAG + g)) |-> v_free[g]);

        p_alloc_lowest_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (issue_ready && v_free[g]) |-> (issue_tag <= TAG_W'(BASE_TAG + g)));

        p_disp_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (disp_valid && v_ready[g]) |-> (disp_tag <= TAG_W'(BASE_TAG + g)));

        p_exec_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (v_exec[g] && !done_hit[g] && !flush) |=> v_exec[g]);

        p_done_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (done_hit[g] && (v_exec[g] || v_drain[g])) |=> v_free[g]);

        p_drain_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (v_drain[g] && !done_hit[g]) |=> v_drain[g]);
    end

endmodule

bind rs_bank rs_bank_chk #(
    .NUM_RS(NUM_RS), .TAG_W(TAG_W), .BASE_TAG(BASE_TAG)
) chk_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .issue_ready(issue_ready), .issue_tag(issue_tag),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_tag(disp_tag),
    .v_free(v_free), .v_wait(v_wait), .v_ready(v_ready),
    .v_exec(v_exec), .v_drain(v_drain), .done_hit(done_hit)
);

// File: tb/rs_bank_tb_top.sv
module rs_bank_tb_top;

    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid, issue_a_rdy, issue_b_rdy;
    logic [2:0]  issue_op;
    logic [15:0] issue_a_val, issue_b_val;
    logic [3:0]  issue_a_tag, issue_b_tag;
    logic        issue_ready;
    logic [3:0]  issue_tag;
    logic        cdb_valid;
    logic [3:0]  cdb_tag;
    logic [15:0] cdb_data;
    logic        disp_valid, disp_ready;
    logic [2:0]  disp_op;
    logic [15:0] disp_a, disp_b;
    logic [3:0]  disp_tag;
    logic        flush, done_valid;
    logic [3:0]  done_tag;

    always #10 clk = ~clk;

    rs_bank #(.NUM_RS(4), .DATA_W(16), .TAG_W(4), .OP_W(3), .BASE_TAG(4)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_a_rdy(issue_a_rdy), .issue_a_val(issue_a_val), .issue_a_tag(issue_a_tag),
        .issue_b_rdy(issue_b_rdy), .issue_b_val(issue_b_val), .issue_b_tag(issue_b_tag),
        .issue_ready(issue_ready), .issue_tag(issue_tag),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_op(disp_op),
        .disp_a(disp_a), .disp_b(disp_b), .disp_tag(disp_tag),
        .flush(flush), .done_valid(done_valid), .done_tag(done_tag)
    );

    // Fixed-latency functional unit model.
    logic       fu_en = 1'b0;
    logic       fu_busy;
    logic [3:0] fu_tag;
    int         fu_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            fu_busy <= 1'b0;
            fu_tag  <= '0;
            fu_cnt  <= 0;
        end else if (disp_valid && disp_ready) begin
            fu_busy <= 1'b1;
            fu_tag  <= disp_tag;
            fu_cnt  <= LAT;
        end else if (fu_busy) begin
            if (fu_cnt == 1) fu_busy <= 1'b0;
            else fu_cnt <= fu_cnt - 1;
        end
    end

    assign disp_ready = fu_en && !fu_busy;
    assign done_valid = fu_busy && (fu_cnt == 1);
    assign done_tag   = fu_tag;

    // Scoreboard.
    typedef struct packed {
        logic [2:0]  op;
        logic [15:0] a;
        logic [15:0] b;
        logic [3:0]  tag;
    } item_t;

    item_t exp_q[$];
    int    total = 0;
    int    bad   = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [2:0] op, input logic [15:0] a,
                        input logic [15:0] b, input logic [3:0] tag);
        item_t it;
        it.op = op; it.a = a; it.b = b; it.tag = tag;
        exp_q.push_back(it);
    endtask

    // Monitor: samples a quarter period before each rising edge.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (rst_n && disp_valid && disp_ready) begin
                item_t got;
                got = {disp_op, disp_a, disp_b, disp_tag};
                total++;
                if (exp_q.size() == 0) begin
                    bad++;
                    $display("FAIL R6 unexpected dispatch: actual=%0h expected=none", got);
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    if (got !== e) begin
                        bad++;
                        $display("FAIL R6 dispatch item: actual=%0h expected=%0h", got, e);
                    end
                end
            end
        end
    end

    task automatic idle();
        issue_valid = 1'b0; issue_op = '0;
        issue_a_rdy = 1'b0; issue_a_val = '0; issue_a_tag = '0;
        issue_b_rdy = 1'b0; issue_b_val = '0; issue_b_tag = '0;
        cdb_valid = 1'b0; cdb_tag = '0; cdb_data = '0;
        flush = 1'b0;
    endtask

    task automatic issue(input logic [2:0] op,
                         input logic ar, input logic [15:0] av, input logic [3:0] at,
                         input logic br, input logic [15:0] bv, input logic [3:0] bt);
        issue_valid = 1'b1; issue_op = op;
        issue_a_rdy = ar; issue_a_val = av; issue_a_tag = at;
        issue_b_rdy = br; issue_b_val = bv; issue_b_tag = bt;
    endtask

    task automatic bcast(input logic [3:0] t, input logic [15:0] d);
        cdb_valid = 1'b1; cdb_tag = t; cdb_data = d;
    endtask

    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic drain_queue();
        for (int k = 0; k < 100 && exp_q.size() != 0; k++) step();
        repeat (6) step();
    endtask

    // Watchdog.
    initial begin
        #(20 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        step(); #1;
        chk("R1 issue_ready", 32'(issue_ready), 32'd1);
        chk("R1 issue_tag", 32'(issue_tag), 32'd4);
        chk("R1 disp_valid", 32'(disp_valid), 32'd0);

        // Fill all stations with the unit held off
        step(); issue(3'd1, 1'b1, 16'd10, 4'd0, 1'b1, 16'd20, 4'd0); #1;
        chk("R2 tag A", 32'(issue_tag), 32'd4);
        push(3'd1, 16'd10, 16'd20, 4'd4);
        step(); issue(3'd2, 1'b0, 16'd0, 4'd9, 1'b1, 16'd5, 4'd0); #1;
        chk("R2 tag B", 32'(issue_tag), 32'd5);
        step(); issue(3'd3, 1'b0, 16'd0, 4'd9, 1'b0, 16'd0, 4'd10); #1;
        chk("R2 tag C", 32'(issue_tag), 32'd6);
        step(); issue(3'd4, 1'b1, 16'd1, 4'd0, 1'b1, 16'd2, 4'd0); #1;
        chk("R2 tag D", 32'(issue_tag), 32'd7);
        step(); issue(3'd7, 1'b1, 16'd99, 4'd0, 1'b1, 16'd99, 4'd0); #1;
        chk("R3 stall", 32'(issue_ready), 32'd0);
        step(); bcast(4'd9, 16'd77);
        step(); bcast(4'd11, 16'd1);   // R4 non-matching tag
        step(); #1;
        chk("R7 lowest ready offered", 32'(disp_tag), 32'd4);
        chk("R6 disp_valid", 32'(disp_valid), 32'd1);
        step(); bcast(4'd10, 16'd88);
        push(3'd2, 16'd77, 16'd5, 4'd5);
        push(3'd3, 16'd77, 16'd88, 4'd6);
        push(3'd4, 16'd1, 16'd2, 4'd7);
        step(); fu_en = 1'b1;
        drain_queue(); #1;
        chk("R8 all freed", 32'(issue_tag), 32'd4);
        chk("R3 dropped issue absent", 32'(exp_q.size()), 32'd0);

        // R5 same-cycle capture at issue
        step(); issue(3'd6, 1'b0, 16'd0, 4'd9, 1'b1, 16'd6, 4'd0); bcast(4'd9, 16'd55); #1;
        chk("R5 tag", 32'(issue_tag), 32'd4);
        push(3'd6, 16'd55, 16'd6, 4'd4);
        step(); #1;
        chk("R5 ready without rebroadcast", 32'(disp_valid), 32'd1);
        drain_queue();

        // R6/R8 exact timing
        step(); issue(3'd5, 1'b1, 16'd3, 4'd0, 1'b1, 16'd4, 4'd0);
        push(3'd5, 16'd3, 16'd4, 4'd4);
        step(); #1;
        chk("R6 next-cycle offer", 32'(disp_valid), 32'd1);
        step(); #1;
        chk("R8 busy after dispatch", 32'(issue_tag), 32'd5);
        step(); #1;
        chk("R8 busy mid-latency", 32'(issue_tag), 32'd5);
        step(); #1;
        chk("R8 busy during completion", 32'(issue_tag), 32'd5);
        step(); #1;
        chk("R8 free after completion", 32'(issue_tag), 32'd4);
        drain_queue();

        // R9/R10 flush with executing, waiting and ready stations
        step(); issue(3'd1, 1'b1, 16'd7, 4'd0, 1'b1, 16'd8, 4'd0);
        push(3'd1, 16'd7, 16'd8, 4'd4);
        step(); issue(3'd2, 1'b0, 16'd0, 4'd9, 1'b1, 16'd1, 4'd0); #1;
        chk("R2 tag Q", 32'(issue_tag), 32'd5);
        step(); issue(3'd3, 1'b1, 16'd2, 4'd0, 1'b1, 16'd3, 4'd0); #1;
        chk("R2 tag R", 32'(issue_tag), 32'd6);
        step(); flush = 1'b1; issue(3'd7, 1'b1, 16'd9, 4'd0, 1'b1, 16'd9, 4'd0); #1;
        chk("R9 issue blocked", 32'(issue_ready), 32'd0);
        chk("R9 dispatch blocked", 32'(disp_valid), 32'd0);
        step(); #1;
        chk("R10 draining station held", 32'(issue_tag), 32'd5);
        chk("R9 ready station dropped", 32'(disp_valid), 32'd0);
        chk("R9 issue reopened", 32'(issue_ready), 32'd1);
        step(); #1;
        chk("R10 freed on completion", 32'(issue_tag), 32'd4);
        step(); bcast(4'd9, 16'd5);
        repeat (8) step();
        #1;
        chk("R9 flushed stations never dispatch", 32'(exp_q.size()), 32'd0);
        chk("R9 bank idle", 32'(disp_valid), 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule